// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one column command of a synchronous DRAM into the stream of per-beat column addresses. It also produces the per-byte data enables for that stream. On a start pulse it captures a start column, the direction (read or write) and the burst settings held in the mode register. These settings are the length code, the order (sequential or interleaved) and a write-single option. From the next cycle on it emits one column per clock. It flags the final beat of a fixed-length burst.

A running burst ends in one of three ways. It runs to its length. It is cut short by a new column command, which restarts sequencing at the new column. Or it is stopped by a terminate pulse, which covers both burst-stop and precharge. In full-page mode the column advances modulo 256 and keeps going until something stops it.

The byte enables follow the data-mask pins. For a write, a mask bit removes its byte in the same cycle. For a read, a mask bit removes its output byte two cycles later.

Top module: `sdr_burst_seq`

## Requirements
- R1: While reset is asserted, beat_valid, last_beat and byte_en are all 0.
- R2: A start sampled at a clock edge makes beat_valid 1 in the following cycle, with col equal to the sampled start_col. Beats then follow at one per cycle.
- R3: bl_code values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. last_beat is 1 only on the final beat, and beat_valid is 0 in the cycle after it unless a new start was sampled.
- R4: In sequential order with length L, beat k carries column (S with its low log2(L) bits cleared) plus ((S + k) mod L), where S is the start column.
- R5: In interleaved order (ilv_mode=1) with a fixed length, beat k carries column S XOR k.
- R6: Any bl_code of 4 or above selects full page. Beat k then carries (S + k) mod 256, ilv_mode is ignored, last_beat stays 0 and the burst continues until a start or a terminate.
- R7: A start sampled during a burst abandons it. The next cycle shows beat 0 of the new burst, with the new column, length, order and direction.
- R8: A terminate sampled without a start makes beat_valid 0 in the next cycle. When start and terminate are sampled together, the start takes effect.
- R9: On a write beat, byte_en[i] equals NOT dqm[i] in the same cycle. Bit 0 is the low byte and bit 1 is the high byte. byte_en is 0 whenever beat_valid is 0.
- R10: On a read beat, byte_en[i] equals NOT the value dqm[i] had two cycles earlier.
- R11: A write started with wr_single=1 is a single beat regardless of bl_code. A read started with wr_single=1 keeps its bl_code length.
- R12: bl_code, ilv_mode, wr_single, start_wr and start_col are used only at a start. Changing them during a burst does not alter its columns, length or enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Column command: begin a burst |
| start_col | input | 8 | Start column of the burst |
| start_wr | input | 1 | 1 for write burst, 0 for read |
| term | input | 1 | Burst stop or precharge |
| dqm | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| bl_code | input | 3 | Burst length code from the mode register |
| ilv_mode | input | 1 | 1 selects interleaved order |
| wr_single | input | 1 | 1 makes write bursts single-beat |
| col | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is issued this cycle |
| last_beat | output | 1 | Current beat is the final one |
| byte_en | output | 2 | Per-byte data enable |

## Verification
The bench builds the block with its defaults: 8-bit columns, fixed lengths up to 8, two byte lanes and a read mask delay of two. With these values it can reach every fixed length and both orders. It also reaches a full-page burst starting at column 250 that wraps through 255 into 0, and codes 4 and 7 both acting as full page. The mode inputs are scrambled after every start, so the capture-only rule is exercised on every burst. Random masks run throughout and are checked against a two-cycle history for reads.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  // Beat ordering inside a fixed-length burst
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;

  // Properties of the burst captured at start
  typedef struct packed {
    logic         wr;
    logic         full;
    burst_order_e ord;
  } burst_kind_t;

endpackage

// File: rtl/sb_burst_ctrl.sv
module sb_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int MAX_LOG = 3,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  input  logic              term,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              ilv_mode,
  input  logic              wr_single,
  output logic              active,
  output logic              cur_wr,
  output burst_order_e      cur_ord,
  output logic [COL_W-1:0]  base,
  output logic [COL_W-1:0]  mask,
  output logic [COL_W-1:0]  cnt,
  output logic              last
);

  logic             active_q, active_d;
  burst_kind_t      kind_q, kind_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] mask_dec;
  logic             full_dec, single_dec, last_int, upd;

  // Length decode: mask = length-1, all ones for full page
  always_comb begin
    single_dec = start_wr & wr_single;
    full_dec   = 1'b0;
    mask_dec   = '0;
    if (!single_dec) begin
      if (bl_code > CODE_W'(MAX_LOG)) begin
        full_dec = 1'b1;
        mask_dec = '1;
      end else begin
        mask_dec = (COL_W'(1) << bl_code) - COL_W'(1);
      end
    end
  end

  assign last_int = active_q & ~kind_q.full & (cnt_q == mask_q);
  assign upd      = start | term | active_q;

  always_comb begin
    active_d = active_q;
    kind_d   = kind_q;
    base_d   = base_q;
    mask_d   = mask_q;
    cnt_d    = cnt_q;
    if (start) begin
      active_d    = 1'b1;
      kind_d.wr   = start_wr;
      kind_d.full = full_dec;
      kind_d.ord  = (ilv_mode && !full_dec) ? ORD_ILV : ORD_SEQ;
      base_d      = start_col;
      mask_d      = mask_dec;
      cnt_d       = '0;
    end else if (term) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (last_int) active_d = 1'b0;
      else          cnt_d    = cnt_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      kind_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
    end else if (upd) begin
      active_q <= active_d;
      kind_q   <= kind_d;
      base_q   <= base_d;
      mask_q   <= mask_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active  = active_q;
  assign cur_wr  = kind_q.wr;
  assign cur_ord = kind_q.ord;
  assign base    = base_q;
  assign mask    = mask_q;
  assign cnt     = cnt_q;
  assign last    = last_int;

  // R3: a final beat with no new command leaves the sequencer idle
  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_int && !start && !term) |=> !active_q);

  // R6: full-page bursts keep running until stopped
  assert_full_page_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && kind_q.full && !start && !term) |=> (active_q && !last_int));

endmodule

// File: rtl/sb_col_gen.sv
module sb_col_gen
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] mask,
  input  logic [COL_W-1:0] cnt,
  input  burst_order_e     ord,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum, seq_col, ilv_col;

  // Sequential: wrap inside the aligned block selected by mask.
  // Full page uses an all-ones mask, giving a plain modulo increment.
  always_comb begin
    sum     = base + cnt;
    seq_col = (base & ~mask) | (sum & mask);
    ilv_col = base ^ cnt;
    col     = (ord == ORD_ILV) ? ilv_col : seq_col;
  end

endmodule

// File: rtl/sb_byte_en.sv
module sb_byte_en #(
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             wr,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] en
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [RD_LAT-1:0] pipe_q;
    if (RD_LAT == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= dqm[g];
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[RD_LAT-2:0], dqm[g]};
      end
    end
    // Write mask acts now; read mask acts RD_LAT cycles later
    assign en[g] = valid & ~(wr ? dqm[g] : pipe_q[RD_LAT-1]);
  end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int COL_W       = 8,
  parameter int MAX_LOG     = 3,
  parameter int CODE_W      = 3,
  parameter int LANES       = 2,
  parameter int RD_MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  input  logic              term,
  input  logic [LANES-1:0]  dqm,
  input  logic [CODE_W-1:0] bl_code,
  input  logic              ilv_mode,
  input  logic              wr_single,
  output logic [COL_W-1:0]  col,
  output logic              beat_valid,
  output logic              last_beat,
  output logic [LANES-1:0]  byte_en
);

  logic             active, cur_wr, last;
  burst_order_e     cur_ord;
  logic [COL_W-1:0] base, mask, cnt;

  sb_burst_ctrl #(.COL_W(COL_W), .MAX_LOG(MAX_LOG), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .start_wr(start_wr), .term(term), .bl_code(bl_code),
    .ilv_mode(ilv_mode), .wr_single(wr_single), .active(active),
    .cur_wr(cur_wr), .cur_ord(cur_ord), .base(base), .mask(mask),
    .cnt(cnt), .last(last)
  );

  sb_col_gen #(.COL_W(COL_W)) u_col (
    .base(base), .mask(mask), .cnt(cnt), .ord(cur_ord), .col(col)
  );

  sb_byte_en #(.LANES(LANES), .RD_LAT(RD_MASK_LAT)) u_ben (
    .clk(clk), .rst_n(rst_n), .valid(active), .wr(cur_wr),
    .dqm(dqm), .en(byte_en)
  );

  assign beat_valid = active;
  assign last_beat  = last;

  // R2: first beat follows the start with the captured column
  assert_first_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col == $past(start_col)));

  // R8: terminate without start silences the next cycle
  assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !start) |=> !beat_valid);

  // R11: single-beat write is its own last beat
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_wr && wr_single) |=> (beat_valid && last_beat));

endmodule

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, start, start_wr, term, ilv_mode, wr_single;
  logic [7:0] start_col, col;
  logic [1:0] dqm, byte_en;
  logic [2:0] bl_code;
  logic       beat_valid, last_beat;

  int  n_cmp = 0, n_bad = 0;
  bit  armed = 0, done = 0;

  typedef struct {
    logic [7:0] col;
    bit         last;
    bit         wr;
    string      tag;
  } exp_t;
  exp_t q[$];

  sdr_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .start_wr(start_wr), .term(term), .dqm(dqm), .bl_code(bl_code),
    .ilv_mode(ilv_mode), .wr_single(wr_single), .col(col),
    .beat_valid(beat_valid), .last_beat(last_beat), .byte_en(byte_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(int s, int k, int len, bit il, bit full);
    if (full) return 8'((s + k) % 256);
    if (il)   return 8'(s ^ k);
    return 8'((s - s % len) + ((s % len + k) % len));
  endfunction

  // Driver: called at a falling edge, returns at the falling edge before
  // the edge where the next command is sampled.
  task automatic issue(input int s, input bit wr, input int code, input bit il,
                       input bit ws, input int n, input bit with_term,
                       input string tag);
    int len; bit full;
    full = 0;
    if (wr && ws)       len = 1;
    else if (code <= 3) len = 1 << code;
    else begin len = 256; full = 1; end
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.col  = exp_col(s, k, len, il, full);
      e.last = !full && (k == len - 1);
      e.wr   = wr;
      e.tag  = tag;
      q.push_back(e);
    end
    start = 1; start_col = 8'(s); start_wr = wr; bl_code = 3'(code);
    ilv_mode = il; wr_single = ws; term = with_term;
    @(negedge clk);
    // R12: scramble every mode input once the burst is captured
    start = 0; term = 0; start_col = ~start_col; bl_code = ~bl_code;
    ilv_mode = ~il; wr_single = ~ws; start_wr = ~wr;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic term_now();
    term = 1;
    @(negedge clk);
    term = 0;
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  // Random byte masks after reset
  initial begin
    dqm = 2'b00;
    forever begin
      @(negedge clk);
      if (rst_n) dqm = 2'($urandom);
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [1:0] p1, p2, cur, xen;
    p1 = 2'b00; p2 = 2'b00;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      cur = dqm;
      if (armed) begin
        if (beat_valid) begin
          if (q.size() == 0) begin
            chk(0, "R8", "unexpected beat col", int'(col), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(col == e.col, e.tag, "col", int'(col), int'(e.col));
            chk(last_beat == e.last, e.tag, "last_beat", int'(last_beat), int'(e.last));
            xen = e.wr ? ~cur : ~p2;
            chk(byte_en == xen, e.wr ? "R9" : "R10", "byte_en",
                int'(byte_en), int'(xen));
          end
        end else begin
          chk(byte_en == 2'b00 && last_beat == 1'b0, "R9", "idle byte_en/last",
              int'({last_beat, byte_en}), 0);
        end
      end
      p2 = p1; p1 = cur;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; start_col = 0; start_wr = 0; term = 0;
    bl_code = 0; ilv_mode = 0; wr_single = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      chk(beat_valid == 0 && last_beat == 0 && byte_en == 0, "R1",
          "reset outputs", int'({beat_valid, last_beat, byte_en}), 0);
    end
    @(negedge clk);
    rst_n = 1;
    armed = 1;
    idle(2);
    issue(6, 0, 2, 0, 0, 4, 0, "R2");         // 6,7,4,5
    idle(2);
    issue(8'hC5, 1, 2, 0, 0, 4, 0, "R4");     // C5,C6,C7,C4
    issue(13, 1, 3, 0, 0, 8, 0, "R4");
    idle(1);
    issue(8'h2B, 0, 3, 1, 0, 8, 0, "R5");     // XOR order
    issue(9, 0, 0, 0, 0, 1, 0, "R3");
    issue(9, 1, 1, 1, 0, 2, 0, "R3");
    idle(2);
    issue(8'h3D, 0, 2, 0, 0, 4, 0, "R12");
    idle(1);
    issue(8'h77, 1, 3, 0, 1, 1, 0, "R11");    // write single
    issue(8'h42, 0, 2, 1, 1, 4, 0, "R11");    // read keeps length
    idle(2);
    issue(250, 0, 7, 1, 0, 12, 0, "R6");      // wraps past 255
    term_now();
    idle(3);
    issue(8'h1F, 1, 4, 0, 0, 3, 0, "R6");
    term_now();
    idle(2);
    issue(8'h30, 1, 3, 0, 0, 3, 0, "R7");     // cut by new start
    issue(8'h85, 0, 2, 1, 0, 4, 0, "R7");
    idle(2);
    issue(8'h10, 0, 3, 0, 0, 2, 0, "R8");
    issue(8'h20, 1, 2, 0, 0, 4, 1, "R8");     // start wins over term
    idle(2);
    issue(8'h5C, 0, 3, 0, 0, 5, 0, "R8");
    term_now();
    idle(4);
    chk(q.size() == 0, "R2", "beats still expected", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule